// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Unit

This block monitors a bank of input pins split into fixed groups of equal width and keeps one sticky interrupt flag per group. A group's flag sets when any pin in that group changes level while its mask bit is one. Both rising and falling transitions count. The block does not care whether the pins are driven from outside or looped back from the chip's own outputs, so software can raise an interrupt by toggling a pin it drives itself.

Each pin first goes through a capture stage, then a synchronizer stage, then a reference register that holds the previously sampled level. A masked difference between the synchronized level and the reference is ORed across the group into a registered set pulse. The set pulse raises the flag. Software clears a flag by pulsing the group's clear strobe. Each request output is the flag gated by a per-group enable. With the default parameters there are two groups of eight pins: pins 7..0 feed group 0 and pins 15..8 feed group 1.

Top module: `pcg_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `flag_o` and `irq_o` are all zero. The pipeline is preloaded with the current pin levels, so pins that are already high at reset do not cause a toggle.
- R2: A change on any pin 7..0 with its mask bit (same index in `mask_i`) at one sets `flag_o[0]` and leaves `flag_o[1]` unchanged.
- R3: A change on any pin 15..8 with its mask bit at one sets `flag_o[1]` and leaves `flag_o[0]` unchanged.
- R4: A rising transition and a falling transition each set the group flag.
- R5: A change on a pin whose mask bit is zero never sets a flag, even when other pins of the same group are unmasked.
- R6: Changing mask bits while the pins are steady never sets a flag.
- R7: A pin change that is applied before rising edge 1 leaves the flag clear after edges 1 to 3 and sets it at edge 4. The mask must stay steady over that window.
- R8: A set flag stays set until `clr_i[g]` is one at a rising edge. The flag then reads zero after that edge. A clear for one group does not affect the other group.
- R9: If a set pulse and a clear strobe for a group meet at the same edge, the flag ends up set.
- R10: `irq_o[g]` equals `flag_o[g] & en_i[g]` for every combination of flags and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 16 | Monitored pin levels; bit `g*8+i` belongs to group g |
| mask_i | input | 16 | Per-pin contribution mask, same bit layout as `pin_i` |
| clr_i | input | 2 | Per-group flag clear strobe (write-one-to-clear) |
| en_i | input | 2 | Per-group interrupt request enable |
| flag_o | output | 2 | Sticky per-group change flags |
| irq_o | output | 2 | Per-group interrupt requests |

## Verification
The hardest case to reach from the ports is a set pulse and a clear strobe landing on the same edge. The set pulse is internal and sits three registers behind the pin. The bench toggles a pin just after a falling edge, counts three rising edges, and raises the clear strobe exactly for the fourth edge. A flag left at one shows that set has priority. The rest of the stimulus sweeps every pin, in both directions, with its own mask bit on and then with only its own mask bit off. This covers group routing, masking and latency for every pin.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int unsigned PCG_NUM_GROUPS = 2;
    localparam int unsigned PCG_GROUP_W    = 8;

    // Per-pin pipeline: capture stage, synchronizer stage, previous sample
    typedef struct packed {
        logic cap;
        logic syn;
        logic prv;
    } pcg_stage_t;

    // Preload value for a stage: every register holds the same level
    function automatic pcg_stage_t pcg_stage_fill(input logic lvl);
        pcg_stage_t s;
        s.cap = lvl;
        s.syn = lvl;
        s.prv = lvl;
        return s;
    endfunction

    // Advance a stage by one clock
    function automatic pcg_stage_t pcg_stage_step(input pcg_stage_t s, input logic lvl);
        pcg_stage_t n;
        n.cap = lvl;
        n.syn = s.cap;
        n.prv = s.syn;
        return n;
    endfunction

    // Masked change detection for one stage
    function automatic logic pcg_changed(input pcg_stage_t s, input logic en);
        return en & (s.syn ^ s.prv);
    endfunction

endpackage

// File: rtl/pcg_pin_track.sv
module pcg_pin_track
    import pcg_pkg::*;
#(
    parameter int unsigned WIDTH = PCG_GROUP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic [WIDTH-1:0] toggle_o
);

    pcg_stage_t stage_q [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= pcg_stage_fill(pin_i[i]);
            end else begin
                stage_q[i] <= pcg_stage_step(stage_q[i], pin_i[i]);
            end
        end

        assign toggle_o[i] = pcg_changed(stage_q[i], mask_i[i]);
    end

endmodule

// File: rtl/pcg_group_flag.sv
module pcg_group_flag
    import pcg_pkg::*;
#(
    parameter int unsigned WIDTH = PCG_GROUP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] toggle_i,
    input  logic             clr_i,
    output logic             flag_o
);

    logic set_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            set_q  <= |toggle_i;
            // set has priority over clear
            flag_q <= set_q | (flag_q & ~clr_i);
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/pcg_unit.sv
module pcg_unit
    import pcg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = PCG_NUM_GROUPS,
    parameter int unsigned GROUP_W    = PCG_GROUP_W,
    localparam int unsigned PIN_W     = NUM_GROUPS * GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PIN_W-1:0]      pin_i,
    input  logic [PIN_W-1:0]      mask_i,
    input  logic [NUM_GROUPS-1:0] clr_i,
    input  logic [NUM_GROUPS-1:0] en_i,
    output logic [NUM_GROUPS-1:0] flag_o,
    output logic [NUM_GROUPS-1:0] irq_o
);

    logic [PIN_W-1:0] toggle;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        pcg_pin_track #(.WIDTH(GROUP_W)) u_track (
            .clk      (clk),
            .rst      (rst),
            .pin_i    (pin_i [g*GROUP_W +: GROUP_W]),
            .mask_i   (mask_i[g*GROUP_W +: GROUP_W]),
            .toggle_o (toggle[g*GROUP_W +: GROUP_W])
        );

        pcg_group_flag #(.WIDTH(GROUP_W)) u_flag (
            .clk      (clk),
            .rst      (rst),
            .toggle_i (toggle[g*GROUP_W +: GROUP_W]),
            .clr_i    (clr_i[g]),
            .flag_o   (flag_o[g])
        );
    end

    assign irq_o = flag_o & en_i;

endmodule

// File: rtl/pcg_unit_chk.sv
module pcg_unit_chk #(
    parameter int unsigned NUM_GROUPS = 2,
    parameter int unsigned GROUP_W    = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_GROUPS*GROUP_W-1:0] mask_i,
    input logic [NUM_GROUPS-1:0]         clr_i,
    input logic [NUM_GROUPS-1:0]         en_i,
    input logic [NUM_GROUPS-1:0]         flag_o,
    input logic [NUM_GROUPS-1:0]         irq_o
);

    // R1: reset empties the flags
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flag_o == '0));

    // R10: a request needs both a flag and an enable
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & ~flag_o) == '0));
    assert_irq_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & ~en_i) == '0));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        // R8: without a clear the flag holds
        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]);

        // R5: a flag only rises if some mask bit of its group was set
        assert_mask_gate_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_o[g]) |-> ($past(mask_i[g*GROUP_W +: GROUP_W], 2) != '0));
    end

endmodule

bind pcg_unit pcg_unit_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mask_i (mask_i),
    .clr_i  (clr_i),
    .en_i   (en_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
);

// File: tb/tb_pcg_unit.sv
module tb_pcg_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pin_i  = 16'h0000;
    logic [15:0] mask_i = 16'h0000;
    logic [1:0]  clr_i  = 2'b00;
    logic [1:0]  en_i   = 2'b00;
    logic [1:0]  flag_o;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pcg_unit dut (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .mask_i (mask_i),
        .clr_i  (clr_i),
        .en_i   (en_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_all();
        clr_i = 2'b11;
        tick();
        clr_i = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [1:0] exp;
        @(negedge clk);
        pin_i = 16'h8001;
        en_i  = 2'b11;
        repeat (4) tick();
        // R1: flags and requests are zero in reset
        check2("R1 flag in reset", flag_o, 2'b00);
        check2("R1 irq in reset", irq_o, 2'b00);
        rst = 1'b0;
        tick();
        check2("R1 flag after reset", flag_o, 2'b00);
        repeat (4) tick();
        check2("R1 no toggle from preloaded high pins", flag_o, 2'b00);
        pin_i = 16'h0000;
        repeat (5) tick();
        clear_all();
        en_i = 2'b00;

        // R2 R3 R4 R5 R7 R8: sweep every pin, both directions, mask on and only-self off
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 2; m++) begin
                for (int d = 0; d < 2; d++) begin
                    mask_i = (m == 0) ? (16'h1 << p) : ~(16'h1 << p);
                    tick();
                    pin_i[p] = ~pin_i[p];
                    exp = (m == 0) ? ((p < 8) ? 2'b01 : 2'b10) : 2'b00;
                    repeat (3) tick();
                    check2("R7 flag still clear after third edge", flag_o, 2'b00);
                    tick();
                    if (m == 0) begin
                        if (p < 8) check2(d == 0 ? "R2 R4 rising group0" : "R2 R4 falling group0", flag_o, exp);
                        else       check2(d == 0 ? "R3 R4 rising group1" : "R3 R4 falling group1", flag_o, exp);
                    end else begin
                        check2("R5 masked pin change ignored", flag_o, exp);
                    end
                    tick();
                    check2("R8 flag holds", flag_o, exp);
                    clear_all();
                    check2("R8 clear strobe empties flag", flag_o, 2'b00);
                end
            end
        end

        // R6: mask changes on steady pins
        pin_i  = 16'hA5C3;
        mask_i = 16'h0000;
        repeat (5) tick();
        mask_i = 16'hFFFF;
        repeat (5) tick();
        check2("R6 mask raise with steady pins", flag_o, 2'b00);
        mask_i = 16'h00F0;
        repeat (5) tick();
        check2("R6 mask change with steady pins", flag_o, 2'b00);

        // R9: set pulse and clear meet at edge 4
        mask_i = 16'hFFFF;
        tick();
        pin_i[3] = ~pin_i[3];
        repeat (3) tick();
        clr_i = 2'b01;
        tick();
        clr_i = 2'b00;
        check2("R9 set wins over clear", flag_o, 2'b01);
        clear_all();

        // R8: clearing one group leaves the other
        pin_i[2]  = ~pin_i[2];
        pin_i[12] = ~pin_i[12];
        repeat (4) tick();
        check2("R2 R3 both groups set", flag_o, 2'b11);
        repeat (20) tick();
        check2("R8 sticky over many cycles", flag_o, 2'b11);

        // R10: request gating over all enable values
        for (int e = 0; e < 4; e++) begin
            en_i = e[1:0];
            tick();
            check2("R10 irq gated by enable", irq_o, e[1:0]);
        end
        clr_i = 2'b01;
        tick();
        clr_i = 2'b00;
        check2("R8 clear group0 only", flag_o, 2'b10);
        for (int e = 0; e < 4; e++) begin
            en_i = e[1:0];
            tick();
            check2("R10 irq with one flag", irq_o, e[1:0] & 2'b10);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule